// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Read Engine

This block lets a system bus read a serial flash as if it were memory. A bus master places a word address on the request port and holds it valid. The block either answers from a small prefetch FIFO or opens a new access on a single-lane serial link. That link has an active-low chip select, a serial clock running at half the system clock, one output data line and one input data line.

The block remembers the address the bus will ask for next. A request that continues the previous read is served from the stream already running, with no new command. For any other address the block flushes the FIFO and releases chip select for a programmable number of system clocks. It then selects the flash again and shifts out a read command and the 24-bit address before it collects data. While chip select stays low, the engine keeps reading words ahead into the FIFO. It stops the serial clock when the FIFO fills.

Two 16-bit enable masks route two events onto sixteen DMA request lines. One event is "FIFO holds data". The other is "a word has just been received". Only the lines below the implemented channel count can ever be driven.

Top module: `qfr_read_engine`

## Requirements
- R1: Out of reset, and with no request, chip select is high, the serial clock is low, `rsp_ready` is low and all sixteen `dma_req` lines are low.
- R2: On a non-continuous access, chip select stays high for exactly `gap_cfg + 1` system clocks between the end of the old burst and the start of the new one. That is 1 clock for 0x0 and 16 clocks for 0xF.
- R3: Each new access shifts out the 8-bit command 0x03 and then the 24-bit request address on `mosi`, most significant bit first. The flash samples `mosi` on the rising edge of `sck`.
- R4: Read data is sampled from `miso` on rising `sck` edges, most significant bit first. The byte at the request address appears in `rsp_data[31:24]`, and the byte at address+3 appears in `rsp_data[7:0]`.
- R5: A request whose address equals the previous request address plus 4 is served without a new command, and chip select stays low.
- R6: The first request after reset, and the first request after `enable` returns high, always starts a new command, whatever its address.
- R7: `rsp_ready` is high only while `req_valid` and `enable` are high and the requested word is in the FIFO. It stays low during the command phase and for the whole time the block is disabled.
- R8: The engine reads ahead at most `FIFO_DEPTH` words beyond those consumed by the bus (default 4). It then holds `sck` low with chip select still low until a word is taken.
- R9: A non-continuous request flushes the FIFO, so the word returned belongs to the new address and never to the old stream.
- R10: `dma_req[i]` is high while the FIFO holds data and `rdy_dma_en[i]` is set.
- R11: When `full_dma_en[i]` is set, `dma_req[i]` pulses high for one clock each time a full 32-bit word has been received.
- R12: Lines at or above `DMA_CHANNELS` (default 4) stay low whatever the enable masks hold.
- R13: While chip select is low and the link is running, `sck` is high for exactly one system clock and low for one. While chip select is high, `sck` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Engine on; low forces deselect, flush and a fresh start |
| gap_cfg | input | 4 | Chip-select high time minus one, in system clocks |
| rdy_dma_en | input | 16 | Per-line enable of the FIFO-data-ready event |
| full_dma_en | input | 16 | Per-line enable of the word-received event |
| req_valid | input | 1 | Bus read request pending |
| req_addr | input | 24 | Byte address of the requested word (word aligned) |
| rsp_ready | output | 1 | Requested word is on `rsp_data` and is taken this clock |
| rsp_data | output | 32 | Read word, lowest address in the top byte |
| cs_n | output | 1 | Flash chip select, active low |
| sck | output | 1 | Serial clock, half the system clock rate |
| mosi | output | 1 | Command and address to the flash |
| miso | input | 1 | Data from the flash |
| dma_req | output | 16 | DMA request lines |

## Verification
A serial flash model returns bytes computed from their address. It records each command and address it receives, counts chip-select rises and measures each chip-select high time. Ascending word reads must keep the command count and chip-select rise count unchanged. Jumps forward by two words, and to distant pages, must raise both counts and return the new page's bytes. Comparing these two cases separates the continuation path from the restart path and catches stale FIFO data. Gap settings of 0, 5 and 15 test the 1, 6 and 16 clock bounds. A long wait after a single read counts the serial bits clocked, which exposes a wrong read-ahead depth. Separate enable-mask patterns show which event feeds which line and that the lines above the implemented channels stay silent.

// File: rtl/qfr_pkg.sv
// Shared definitions for the serial flash read engine.
package qfr_pkg;
    // Link phases of the serial engine.
    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_GAP  = 2'd1,
        ENG_CMD  = 2'd2,
        ENG_DATA = 2'd3
    } eng_state_t;

    localparam logic [7:0] READ_OPCODE = 8'h03;
    localparam int         OPCODE_W    = 8;
endpackage

// File: rtl/qfr_fifo.sv
// Prefetch FIFO: single clock, synchronous flush that overrides push and pop.
// Assumes DEPTH is a power of two and that push is never given when full.
module qfr_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             empty,
    output logic             full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [AW:0]      count;

    assign empty = (count == '0);
    assign full  = (count == (AW+1)'(DEPTH));
    assign rdata = mem[rd_ptr];

    // Storage write; data content needs no reset.
    always_ff @(posedge clk) begin
        if (push && !full)
            mem[wr_ptr] <= wdata;
    end

    // Pointer and occupancy tracking with flush priority.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push && !full)
                wr_ptr <= wr_ptr + 1'b1;
            if (pop && !empty)
                rd_ptr <= rd_ptr + 1'b1;
            case ({push && !full, pop && !empty})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/qfr_link.sv
// Serial link engine: chip-select gap, command plus address shift-out, then
// continuous word reception. SCK toggles every system clock while running.
// Assumes start is a one-clock pulse; hold is sampled only at word boundaries.
module qfr_link
    import qfr_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int WORD_W = 32,
    parameter int GAP_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [GAP_W-1:0]  gap_cfg,
    input  logic              hold,
    input  logic              miso,
    output logic              cs_n,
    output logic              sck,
    output logic              mosi,
    output logic              word_valid,
    output logic [WORD_W-1:0] word
);
    localparam int CMD_BITS = OPCODE_W + ADDR_W;
    localparam int CNT_MAX  = (CMD_BITS > WORD_W) ? CMD_BITS : WORD_W;
    localparam int CNT_W    = $clog2(CNT_MAX);

    eng_state_t          state;
    logic [GAP_W-1:0]    gap_cnt;
    logic [CNT_W-1:0]    bit_cnt;
    logic [CMD_BITS-1:0] tx_sh;
    logic [WORD_W-1:0]   rx_sh;

    // Phase and shift sequencing for the serial link.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            state   <= ENG_IDLE;
            sck     <= 1'b0;
            gap_cnt <= '0;
            bit_cnt <= '0;
            tx_sh   <= '0;
            rx_sh   <= '0;
        end else if (start) begin
            state   <= ENG_GAP;
            sck     <= 1'b0;
            gap_cnt <= gap_cfg;
            bit_cnt <= '0;
            tx_sh   <= {READ_OPCODE, start_addr};
        end else begin
            case (state)
                ENG_GAP: begin
                    if (gap_cnt == '0)
                        state <= ENG_CMD;
                    else
                        gap_cnt <= gap_cnt - 1'b1;
                end
                ENG_CMD: begin
                    sck <= ~sck;
                    if (sck) begin
                        tx_sh <= {tx_sh[CMD_BITS-2:0], 1'b0};
                        if (bit_cnt == CNT_W'(CMD_BITS - 1)) begin
                            state   <= ENG_DATA;
                            bit_cnt <= '0;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                end
                ENG_DATA: begin
                    if (!sck) begin
                        if (!(bit_cnt == '0 && hold)) begin
                            sck   <= 1'b1;
                            rx_sh <= {rx_sh[WORD_W-2:0], miso};
                        end
                    end else begin
                        sck <= 1'b0;
                        if (bit_cnt == CNT_W'(WORD_W - 1))
                            bit_cnt <= '0;
                        else
                            bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end

    // Output decode from the phase register.
    always_comb begin
        cs_n       = (state == ENG_IDLE) || (state == ENG_GAP);
        mosi       = (state == ENG_CMD) ? tx_sh[CMD_BITS-1] : 1'b0;
        word_valid = (state == ENG_DATA) && sck && (bit_cnt == CNT_W'(WORD_W - 1));
        word       = rx_sh;
    end
endmodule

// File: rtl/qfr_dma_gate.sv
// DMA request gating: two events masked per line; lines above the
// implemented channel count are tied low.
module qfr_dma_gate #(
    parameter int LINES    = 16,
    parameter int CHANNELS = 4
) (
    input  logic [LINES-1:0] rdy_en,
    input  logic [LINES-1:0] full_en,
    input  logic             data_ready,
    input  logic             word_done,
    output logic [LINES-1:0] req
);
    // One gate per line, selected by implementation.
    for (genvar i = 0; i < LINES; i++) begin : g_line
        if (i < CHANNELS) begin : g_impl
            assign req[i] = (rdy_en[i] & data_ready) | (full_en[i] & word_done);
        end else begin : g_none
            assign req[i] = 1'b0;
        end
    end
endmodule

// File: rtl/qfr_read_engine.sv
// Top of the memory-mapped serial flash read engine. Tracks the next expected
// bus address; a matching request is served from the prefetch FIFO, any
// other restarts the link after a flush. Assumes word-aligned addresses and
// that req_addr stays stable while req_valid is high.
module qfr_read_engine #(
    parameter int ADDR_W       = 24,
    parameter int WORD_W       = 32,
    parameter int GAP_W        = 4,
    parameter int FIFO_DEPTH   = 4,
    parameter int DMA_LINES    = 16,
    parameter int DMA_CHANNELS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic [GAP_W-1:0]     gap_cfg,
    input  logic [DMA_LINES-1:0] rdy_dma_en,
    input  logic [DMA_LINES-1:0] full_dma_en,
    input  logic                 req_valid,
    input  logic [ADDR_W-1:0]    req_addr,
    output logic                 rsp_ready,
    output logic [WORD_W-1:0]    rsp_data,
    output logic                 cs_n,
    output logic                 sck,
    output logic                 mosi,
    input  logic                 miso,
    output logic [DMA_LINES-1:0] dma_req
);
    localparam int WORD_BYTES = WORD_W / 8;

    logic [ADDR_W-1:0] next_addr;
    logic              stream_ok;
    logic              addr_match, restart;
    logic              fifo_empty, fifo_full;
    logic              word_valid;
    logic [WORD_W-1:0] word;

    // Request classification: continuation versus restart.
    always_comb begin
        addr_match = stream_ok && (req_addr == next_addr);
        rsp_ready  = enable && req_valid && addr_match && !fifo_empty;
        restart    = enable && req_valid && !addr_match;
    end

    // Next expected address and stream validity.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            stream_ok <= 1'b0;
            next_addr <= '0;
        end else if (restart) begin
            stream_ok <= 1'b1;
            next_addr <= req_addr;
        end else if (rsp_ready) begin
            next_addr <= next_addr + ADDR_W'(WORD_BYTES);
        end
    end

    qfr_link #(
        .ADDR_W (ADDR_W),
        .WORD_W (WORD_W),
        .GAP_W  (GAP_W)
    ) u_link (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .start      (restart),
        .start_addr (req_addr),
        .gap_cfg    (gap_cfg),
        .hold       (fifo_full),
        .miso       (miso),
        .cs_n       (cs_n),
        .sck        (sck),
        .mosi       (mosi),
        .word_valid (word_valid),
        .word       (word)
    );

    qfr_fifo #(
        .WIDTH (WORD_W),
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (restart || !enable),
        .push  (word_valid),
        .wdata (word),
        .pop   (rsp_ready),
        .rdata (rsp_data),
        .empty (fifo_empty),
        .full  (fifo_full)
    );

    qfr_dma_gate #(
        .LINES    (DMA_LINES),
        .CHANNELS (DMA_CHANNELS)
    ) u_dma (
        .rdy_en     (rdy_dma_en),
        .full_en    (full_dma_en),
        .data_ready (!fifo_empty),
        .word_done  (word_valid),
        .req        (dma_req)
    );
endmodule

// File: rtl/qfr_read_engine_chk.sv
// Property checker for the read engine, attached by bind.
module qfr_read_engine_chk #(
    parameter int GAP_W        = 4,
    parameter int DMA_LINES    = 16,
    parameter int DMA_CHANNELS = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 enable,
    input logic [GAP_W-1:0]     gap_cfg,
    input logic                 req_valid,
    input logic                 rsp_ready,
    input logic                 cs_n,
    input logic                 sck,
    input logic [DMA_LINES-1:0] dma_req
);
    localparam logic [DMA_LINES-1:0] IMPL_MASK =
        {DMA_LINES{1'b1}} >> (DMA_LINES - DMA_CHANNELS);
    localparam int HC_W = GAP_W + 1;

    logic [HC_W-1:0] hi_cnt;
    logic            cs_prev;

    // Counts clocks of chip-select high, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt  <= '0;
            cs_prev <= 1'b1;
        end else begin
            cs_prev <= cs_n;
            if (!cs_n)
                hi_cnt <= '0;
            else if (hi_cnt != {HC_W{1'b1}})
                hi_cnt <= hi_cnt + 1'b1;
        end
    end

    AST_CS_GAP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_prev && !cs_n) |-> (hi_cnt > HC_W'(gap_cfg))); // R2
    AST_SCK_LOW_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck); // R13
    AST_SCK_ONE_CYCLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        sck |=> !sck); // R13
    AST_READY_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ready |-> req_valid); // R7
    AST_OFF_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> !rsp_ready); // R7
    AST_UNUSED_DMA_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req & ~IMPL_MASK) == '0); // R12
endmodule

bind qfr_read_engine qfr_read_engine_chk #(
    .GAP_W        (GAP_W),
    .DMA_LINES    (DMA_LINES),
    .DMA_CHANNELS (DMA_CHANNELS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .gap_cfg   (gap_cfg),
    .req_valid (req_valid),
    .rsp_ready (rsp_ready),
    .cs_n      (cs_n),
    .sck       (sck),
    .dma_req   (dma_req)
);

// File: tb/qfr_read_engine_bench.sv
`timescale 1ns/1ps
// Directed bench with a behavioural serial flash model.
module qfr_read_engine_bench;
    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [3:0]  gap_cfg = 4'd0;
    logic [15:0] rdy_dma_en = '0;
    logic [15:0] full_dma_en = '0;
    logic        req_valid = 1'b0;
    logic [23:0] req_addr = '0;
    logic        rsp_ready;
    logic [31:0] rsp_data;
    logic        cs_n, sck, mosi;
    logic        miso = 1'b0;
    logic [15:0] dma_req;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    qfr_read_engine u_qfr_read_engine (
        .clk(clk), .rst_n(rst_n), .enable(enable), .gap_cfg(gap_cfg),
        .rdy_dma_en(rdy_dma_en), .full_dma_en(full_dma_en),
        .req_valid(req_valid), .req_addr(req_addr),
        .rsp_ready(rsp_ready), .rsp_data(rsp_data),
        .cs_n(cs_n), .sck(sck), .mosi(mosi), .miso(miso), .dma_req(dma_req)
    );

    // Flash content as a function of address.
    function automatic logic [7:0] fbyte(input logic [23:0] a);
        return (a[7:0] * 8'd7) ^ a[15:8] ^ 8'h3C;
    endfunction

    function automatic logic [31:0] fword(input logic [23:0] a);
        return {fbyte(a), fbyte(a + 24'd1), fbyte(a + 24'd2), fbyte(a + 24'd3)};
    endfunction

    // Flash model: mode 0, samples on rising SCK, drives on falling SCK.
    int          fm_bits = 0;
    int          fm_cmds = 0;
    int          cs_rises = 0;
    logic [31:0] fm_sh = '0;
    logic [7:0]  fm_cmd = '0;
    logic [23:0] fm_addr = '0;

    always @(posedge sck) begin
        if (!cs_n) begin
            if (fm_bits < 32) fm_sh = {fm_sh[30:0], mosi};
            fm_bits++;
            if (fm_bits == 32) begin
                fm_cmd  = fm_sh[31:24];
                fm_addr = fm_sh[23:0];
                fm_cmds++;
            end
        end
    end

    always @(negedge sck) begin
        if (!cs_n && fm_bits >= 32) begin
            int          d;
            logic [7:0]  b;
            d = fm_bits - 32;
            b = fbyte(fm_addr + 24'(d / 8));
            miso = b[7 - (d % 8)];
        end
    end

    always @(posedge cs_n) begin
        fm_bits = 0;
        cs_rises++;
    end

    // Chip-select high time and SCK shape monitors.
    int   hi_run = 0;
    int   last_gap = 0;
    int   sck_bad = 0;
    int   full_pulses = 0;
    logic sck_prev = 1'b0;
    always @(negedge clk) begin
        if (cs_n) hi_run++;
        else if (hi_run > 0) begin
            last_gap = hi_run;
            hi_run = 0;
        end
        if (sck && sck_prev) sck_bad++;
        sck_prev = sck;
        if (dma_req[2]) full_pulses++;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic do_read(input logic [23:0] a, output logic [31:0] d, output int cyc);
        @(negedge clk);
        req_addr  = a;
        req_valid = 1'b1;
        cyc = 0;
        d = '0;
        while (cyc < 3000) begin
            @(negedge clk);
            cyc++;
            if (rsp_ready) begin
                d = rsp_data;
                break;
            end
        end
        @(posedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(cs_n == 1'b1, "R1", "cs_n", 32'(cs_n), 32'd1);
        chk(sck == 1'b0, "R1", "sck", 32'(sck), 32'd0);
        chk(rsp_ready == 1'b0, "R1", "rsp_ready", 32'(rsp_ready), 32'd0);
        chk(dma_req == '0, "R1", "dma_req", 32'(dma_req), 32'd0);
    endtask

    task automatic t_first_read;
        logic [31:0] d;
        int c;
        do_read(24'h000100, d, c);
        chk(fm_cmds == 1, "R6", "commands after first read", 32'(fm_cmds), 32'd1);
        chk(fm_cmd == 8'h03, "R3", "opcode", 32'(fm_cmd), 32'h03);
        chk(fm_addr == 24'h000100, "R3", "address", 32'(fm_addr), 32'h100);
        chk(d == fword(24'h000100), "R4", "first word", d, fword(24'h000100));
        chk(c > 64, "R7", "ready latency above command time", 32'(c), 32'd65);
    endtask

    task automatic t_sequential;
        logic [31:0] d;
        int c;
        int cmds0 = fm_cmds;
        int rises0 = cs_rises;
        for (int i = 1; i <= 7; i++) begin
            logic [23:0] a = 24'h000100 + 24'(4 * i);
            do_read(a, d, c);
            chk(d == fword(a), "R5", "sequential word", d, fword(a));
        end
        chk(fm_cmds == cmds0, "R5", "no new command", 32'(fm_cmds), 32'(cmds0));
        chk(cs_rises == rises0, "R5", "chip select held", 32'(cs_rises), 32'(rises0));
    endtask

    task automatic t_jump(input logic [3:0] cfg, input logic [23:0] a);
        logic [31:0] d;
        int c;
        int cmds0 = fm_cmds;
        @(negedge clk);
        gap_cfg = cfg;
        do_read(a, d, c);
        chk(last_gap == int'(cfg) + 1, "R2", "chip select gap", 32'(last_gap), 32'(cfg) + 1);
        chk(fm_cmds == cmds0 + 1, "R2", "new command on jump", 32'(fm_cmds), 32'(cmds0 + 1));
        chk(fm_addr == a, "R3", "jump address", 32'(fm_addr), 32'(a));
        chk(d == fword(a), "R9", "word after flush", d, fword(a));
    endtask

    task automatic t_readahead;
        logic [31:0] d;
        int c;
        do_read(24'h004000, d, c);
        repeat (600) @(negedge clk);
        chk(fm_bits == 32 + 32 * (DEPTH + 1), "R8", "bits clocked ahead",
            32'(fm_bits), 32'(32 + 32 * (DEPTH + 1)));
        chk(sck == 1'b0 && cs_n == 1'b0, "R8", "paused selected with sck low",
            {30'd0, cs_n, sck}, 32'd0);
    endtask

    task automatic t_dma;
        logic [31:0] d;
        int c, p0;
        @(negedge clk);
        rdy_dma_en = 16'h0003;
        @(negedge clk);
        chk(dma_req == 16'h0003, "R10", "data-ready lines", 32'(dma_req), 32'h3);
        rdy_dma_en = 16'hFFFF;
        @(negedge clk);
        chk(dma_req == 16'h000F, "R12", "upper lines silent", 32'(dma_req), 32'hF);
        rdy_dma_en = 16'h0000;
        full_dma_en = 16'h0004;
        p0 = full_pulses;
        do_read(24'h006000, d, c);
        repeat (600) @(negedge clk);
        chk(full_pulses - p0 == DEPTH + 1, "R11", "word-received pulses",
            32'(full_pulses - p0), 32'(DEPTH + 1));
        full_dma_en = 16'h0000;
    endtask

    task automatic t_disable;
        logic [31:0] d;
        int c;
        int cmds0;
        bit seen = 1'b0;
        @(negedge clk);
        rdy_dma_en = 16'h0003;
        enable = 1'b0;
        req_addr = 24'h006004;
        req_valid = 1'b1;
        repeat (40) begin
            @(negedge clk);
            if (rsp_ready) seen = 1'b1;
        end
        chk(!seen, "R7", "no ready while disabled", 32'(seen), 32'd0);
        chk(cs_n == 1'b1 && dma_req == '0, "R7", "deselected and flushed",
            {15'd0, cs_n, dma_req}, 32'h10000);
        req_valid = 1'b0;
        rdy_dma_en = '0;
        enable = 1'b1;
        cmds0 = fm_cmds;
        do_read(24'h006004, d, c);
        chk(fm_cmds == cmds0 + 1, "R6", "command after re-enable", 32'(fm_cmds), 32'(cmds0 + 1));
        chk(d == fword(24'h006004), "R4", "word after re-enable", d, fword(24'h006004));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        rst_n = 1'b1;
        t_reset();
        enable = 1'b1;
        t_first_read();
        t_sequential();
        t_jump(4'd5, 24'h002000);
        t_jump(4'd0, 24'h002008);
        t_jump(4'd15, 24'h00A0F0);
        t_readahead();
        t_dma();
        t_disable();
        chk(sck_bad == 0, "R13", "sck high over two clocks", 32'(sck_bad), 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule